// File: doc/BRIEF.md
# Stack-Based Byte-Code Processor Core

This core runs programs made of one-byte opcodes and keeps every operand on a stack that lives in the same memory as the program. It has no register file. A stack pointer register addresses the top word, and every push or pop goes through the single memory port. The opcodes carry their own small operands: a 7-bit signed immediate, or a 5-bit word offset from the stack pointer. The core never fetches extra operand bytes.

The hardware runs a small base set of operations: push immediate, load relative to the stack pointer, add, store, call, jump to a popped address, and no-op. Any other byte is not decoded further. The core saves the address of the next byte on the stack and jumps to a fixed emulation address, where software carries out the operation. Two immediate pushes in a row combine into one wider constant.

The memory port is plain control with no back-pressure. The core drives an address with either a read strobe or a write strobe. Read data must come back on the next cycle. A write lands at the clock edge where its strobe is high. The port always has a single user, so no valid/ready handshake is needed. Words are 32 bits wide and byte addresses are word aligned on the port.

Top module: `zsp_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the core reads word address 0 (PC reset to 0) and issues no write. The stack pointer restarts at parameter SP_INIT.
- R2: An opcode with bit 7 set pushes bits 6:0, sign-extended to 32 bits. The push writes at SP-4 and leaves SP = SP-4.
- R3: When an immediate push directly follows another immediate push, nothing new is pushed. Instead the top word becomes (top << 7) | bits 6:0.
- R4: Any opcode other than an immediate push ends a chain, so the next immediate push is a fresh, sign-extended push. No-op is 0x0B.
- R5: Opcode 0x05 pops two words and pushes their sum. The result lands at the old SP+4, and SP grows by 4.
- R6: An opcode with bits 7:5 = 011 pushes the word at SP + 4*bits 4:0. SP is the value before the push.
- R7: Opcode 0x0C pops an address (the top word), then pops the data word, and writes the data to that address with bits 1:0 cleared. SP grows by 8.
- R8: Opcode 0x2D replaces the top word (the target) with the byte address of the next opcode and continues at the target. SP is unchanged.
- R9: Opcode 0x04 pops the top word into PC.
- R10: Every other opcode pushes the address of the next opcode and continues at parameter EMU_VEC.
- R11: Opcodes are fetched from the word at PC with bits 1:0 cleared. Byte lane PC[1:0]=0 is bits 31:24 (big-endian). Every port access is word aligned.
- R12: Read and write strobes are never high together. Each instruction writes at most once, and a write is always followed by the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_rd_en | output | 1 | Read strobe; data is returned next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd_en |

## Verification
The bench targets these corner cases:
- Chains of immediates, including a negative seed and a three-deep chain. A core that sign-extends on every push, or never clears its chain flag, leaves the wrong constant on the stack.
- A stack-relative load with offset 0. A core that scales the offset badly, or reads after moving SP, duplicates the wrong word.
- Call and pop-to-PC, judged by stack cells that only a fall-through would touch. A wrong return value or a missing jump shows up there.
- Traps on two unimplemented bytes. These expose a wrong saved address or a wrong vector.
- A reset in the middle of an instruction. It catches a core whose PC or state survives reset.

// File: rtl/zsp_pkg.sv
package zsp_pkg;
  typedef enum logic [2:0] {
    OP_IMM, OP_LDSP, OP_ADD, OP_STORE, OP_CALL, OP_POPPC, OP_NOP, OP_TRAP
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH, ST_DECODE, ST_READ1, ST_READ2
  } st_e;

  localparam int IMM_BITS = 7;
  localparam int OFF_BITS = 5;

  localparam logic [7:0] CODE_ADD   = 8'h05;
  localparam logic [7:0] CODE_STORE = 8'h0C;
  localparam logic [7:0] CODE_CALL  = 8'h2D;
  localparam logic [7:0] CODE_POPPC = 8'h04;
  localparam logic [7:0] CODE_NOP   = 8'h0B;
  localparam logic [2:0] LDSP_TAG   = 3'b011;
endpackage

// File: rtl/zsp_decode.sv
module zsp_decode
  import zsp_pkg::*;
(
  input  logic [7:0]          opcode,
  output op_e                 op,
  output logic [IMM_BITS-1:0] imm,
  output logic [OFF_BITS-1:0] off
);
  always_comb begin
    imm = opcode[IMM_BITS-1:0];
    off = opcode[OFF_BITS-1:0];
    if (opcode[7]) begin
      op = OP_IMM;
    end else if (opcode[7:5] == LDSP_TAG) begin
      op = OP_LDSP;
    end else begin
      case (opcode)
        CODE_ADD:   op = OP_ADD;
        CODE_STORE: op = OP_STORE;
        CODE_CALL:  op = OP_CALL;
        CODE_POPPC: op = OP_POPPC;
        CODE_NOP:   op = OP_NOP;
        default:    op = OP_TRAP;
      endcase
    end
  end
endmodule

// File: rtl/zsp_lane_sel.sv
module zsp_lane_sel #(
  parameter int W = 32,
  localparam int LANES = W / 8,
  localparam int LSB = $clog2(LANES)
) (
  input  logic [W-1:0]   word,
  input  logic [LSB-1:0] lane,
  output logic [7:0]     opcode
);
  // Big-endian: lane 0 is the most significant byte.
  always_comb begin
    opcode = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane == LSB'(i)) opcode = word[W-1-8*i -: 8];
    end
  end
endmodule

// File: rtl/zsp_calc.sv
module zsp_calc
  import zsp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [IMM_BITS-1:0] imm,
  input  logic [W-1:0]        tos,
  input  logic [W-1:0]        opa,
  input  logic [W-1:0]        opb,
  output logic [W-1:0]        sext,
  output logic [W-1:0]        merged,
  output logic [W-1:0]        sum
);
  assign sext   = {{(W-IMM_BITS){imm[IMM_BITS-1]}}, imm};
  assign merged = (tos << IMM_BITS) | W'(imm);
  assign sum    = opa + opb;
endmodule

// File: rtl/zsp_core.sv
module zsp_core
  import zsp_pkg::*;
#(
  parameter int          W       = 32,
  parameter logic [31:0] SP_INIT = 32'h0000_FFF8,
  parameter logic [31:0] EMU_VEC = 32'h0000_0020
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  output logic         mem_rd_en,
  output logic         mem_wr_en,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata
);
  localparam int LSB  = $clog2(W / 8);
  localparam int STEP = W / 8;

  st_e                 st;
  op_e                 opr;
  logic [W-1:0]        pc, sp, tmp;
  logic [IMM_BITS-1:0] imm_r;
  logic [OFF_BITS-1:0] off_r;
  logic                chain;

  logic [7:0]          cur_byte;
  op_e                 dop;
  logic [IMM_BITS-1:0] dimm;
  logic [OFF_BITS-1:0] doff;
  logic [W-1:0]        sext_v, merged_v, sum_v;
  logic [W-1:0]        pc_next, sp_dn, sp_up, sp_up2, ld_addr, st_addr;

  zsp_lane_sel #(.W(W)) u_lane (
    .word(mem_rdata), .lane(pc[LSB-1:0]), .opcode(cur_byte)
  );

  zsp_decode u_dec (.opcode(cur_byte), .op(dop), .imm(dimm), .off(doff));

  zsp_calc #(.W(W)) u_calc (
    .imm(st == ST_DECODE ? dimm : imm_r), .tos(mem_rdata),
    .opa(tmp), .opb(mem_rdata),
    .sext(sext_v), .merged(merged_v), .sum(sum_v)
  );

  assign pc_next = pc + W'(1);
  assign sp_dn   = sp - W'(STEP);
  assign sp_up   = sp + W'(STEP);
  assign sp_up2  = sp + W'(2 * STEP);
  assign ld_addr = sp + (W'(doff) << LSB);
  assign st_addr = {tmp[W-1:LSB], LSB'(0)};

  // Port drive, decoded from the current state.
  always_comb begin
    mem_addr  = '0;
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_wdata = '0;
    case (st)
      ST_FETCH: begin
        mem_addr  = {pc[W-1:LSB], LSB'(0)};
        mem_rd_en = 1'b1;
      end
      ST_DECODE: begin
        case (dop)
          OP_IMM: begin
            if (chain) begin
              mem_addr = sp; mem_rd_en = 1'b1;
            end else begin
              mem_addr = sp_dn; mem_wr_en = 1'b1; mem_wdata = sext_v;
            end
          end
          OP_LDSP: begin mem_addr = ld_addr; mem_rd_en = 1'b1; end
          OP_ADD, OP_STORE, OP_CALL, OP_POPPC: begin
            mem_addr = sp; mem_rd_en = 1'b1;
          end
          OP_TRAP: begin
            mem_addr = sp_dn; mem_wr_en = 1'b1; mem_wdata = pc_next;
          end
          default: ;
        endcase
      end
      ST_READ1: begin
        case (opr)
          OP_IMM:  begin mem_addr = sp; mem_wr_en = 1'b1; mem_wdata = merged_v; end
          OP_LDSP: begin mem_addr = sp_dn; mem_wr_en = 1'b1; mem_wdata = mem_rdata; end
          OP_ADD, OP_STORE: begin mem_addr = sp_up; mem_rd_en = 1'b1; end
          OP_CALL: begin mem_addr = sp; mem_wr_en = 1'b1; mem_wdata = pc_next; end
          default: ;
        endcase
      end
      ST_READ2: begin
        if (opr == OP_ADD) begin
          mem_addr = sp_up; mem_wr_en = 1'b1; mem_wdata = sum_v;
        end else begin
          mem_addr = st_addr; mem_wr_en = 1'b1; mem_wdata = mem_rdata;
        end
      end
      default: ;
    endcase
  end

  // Sequencer and architectural state.
  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_FETCH;
      opr   <= OP_NOP;
      pc    <= '0;
      sp    <= W'(SP_INIT);
      tmp   <= '0;
      imm_r <= '0;
      off_r <= '0;
      chain <= 1'b0;
    end else begin
      case (st)
        ST_FETCH: st <= ST_DECODE;
        ST_DECODE: begin
          opr   <= dop;
          imm_r <= dimm;
          off_r <= doff;
          chain <= (dop == OP_IMM);
          case (dop)
            OP_IMM: begin
              if (chain) st <= ST_READ1;
              else begin sp <= sp_dn; pc <= pc_next; st <= ST_FETCH; end
            end
            OP_NOP:  begin pc <= pc_next; st <= ST_FETCH; end
            OP_TRAP: begin sp <= sp_dn; pc <= W'(EMU_VEC); st <= ST_FETCH; end
            default: st <= ST_READ1;
          endcase
        end
        ST_READ1: begin
          case (opr)
            OP_IMM:  begin pc <= pc_next; st <= ST_FETCH; end
            OP_LDSP: begin sp <= sp_dn; pc <= pc_next; st <= ST_FETCH; end
            OP_ADD, OP_STORE: begin tmp <= mem_rdata; st <= ST_READ2; end
            OP_CALL:  begin pc <= mem_rdata; st <= ST_FETCH; end
            OP_POPPC: begin pc <= mem_rdata; sp <= sp_up; st <= ST_FETCH; end
            default:  st <= ST_FETCH;
          endcase
        end
        ST_READ2: begin
          sp <= (opr == OP_ADD) ? sp_up : sp_up2;
          pc <= pc_next;
          st <= ST_FETCH;
        end
        default: st <= ST_FETCH;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^off_r;
endmodule

// File: rtl/zsp_core_chk.sv
module zsp_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] mem_addr,
  input logic         mem_rd_en,
  input logic         mem_wr_en
);
  localparam int LSB = $clog2(W / 8);

  p_boot_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_rd_en && !mem_wr_en && mem_addr == '0));

  p_aligned_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en || mem_wr_en) |-> (mem_addr[LSB-1:0] == '0));

  p_port_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  p_write_then_fetch_r12: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> (mem_rd_en && !mem_wr_en));
endmodule

bind zsp_core zsp_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en)
);

// File: tb/tb_zsp_core.sv
module tb_zsp_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd_en, mem_wr_en;

  always #4 clk = ~clk;  // 125 MHz

  zsp_core #(.W(32), .SP_INIT(32'h0000_03F8), .EMU_VEC(32'h0000_0020)) dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Bench memory: 256 words, one-cycle read latency.
  logic [31:0] mem [256];
  logic        clr = 1'b0, ld = 1'b0;
  logic [7:0]  ld_idx = '0;
  logic [31:0] ld_dat = '0;

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else begin
      if (ld) mem[ld_idx] <= ld_dat;
      if (mem_wr_en) mem[mem_addr[9:2]] <= mem_wdata;
    end
    if (mem_rd_en) mem_rdata <= mem[mem_addr[9:2]];
  end

  int n_cmp = 0, n_bad = 0;
  int dbl_wr = 0, misalign = 0, overlap = 0;
  logic prev_we = 1'b0;
  bit done = 1'b0;

  // Port monitor (R11, R12), sampled away from the edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_wr_en && prev_we) dbl_wr++;
      if ((mem_rd_en || mem_wr_en) && mem_addr[1:0] != 2'b00) misalign++;
      if (mem_rd_en && mem_wr_en) overlap++;
      prev_we = mem_wr_en;
    end else prev_we = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] w0;
    logic [31:0] w1;
    logic [7:0]  req;
    logic [15:0] a0;
    logic [31:0] e0;
    logic [15:0] a1;
    logic [31:0] e1;
  } vec_t;

  // Program bytes 0..7; bytes 6,7 = 86 04 is a self-loop at address 6.
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{32'h850B0B0B, 32'h0B0B8604, 8'd2,  16'h3F4, 32'h00000005, 16'h3F0, 32'h00000006}, // R2
    '{32'hFD0B0B0B, 32'h0B0B8604, 8'd2,  16'h3F4, 32'hFFFFFFFD, 16'h3EC, 32'h00000000}, // R2 negative
    '{32'h81820B0B, 32'h0B0B8604, 8'd3,  16'h3F4, 32'h00000082, 16'h3F0, 32'h00000006}, // R3
    '{32'hFF800B0B, 32'h0B0B8604, 8'd3,  16'h3F4, 32'hFFFFFF80, 16'h3F0, 32'h00000006}, // R3 negative seed
    '{32'h810B820B, 32'h0B0B8604, 8'd4,  16'h3F4, 32'h00000001, 16'h3F0, 32'h00000002}, // R4 nop breaks
    '{32'h830B8405, 32'h0B0B8604, 8'd5,  16'h3F4, 32'h00000007, 16'h3F0, 32'h00000006}, // R5
    '{32'h890B8A61, 32'h0B0B8604, 8'd6,  16'h3EC, 32'h00000009, 16'h3F0, 32'h0000000A}, // R6
    '{32'hAA0BB00C, 32'h0B0B8604, 8'd7,  16'h030, 32'h0000002A, 16'h3F4, 32'h00000006}, // R7
    '{32'h862D850B, 32'h0B0B8604, 8'd8,  16'h3F4, 32'h00000002, 16'h3EC, 32'h00000000}, // R8
    '{32'h8604850B, 32'h0B0B8604, 8'd9,  16'h3F4, 32'h00000006, 16'h3F0, 32'h00000000}, // R9
    '{32'h85000B0B, 32'h0B0B8604, 8'd10, 16'h3F0, 32'h00000002, 16'h3EC, 32'h00000020}, // R10
    '{32'h2E0B0B0B, 32'h0B0B8604, 8'd10, 16'h3F4, 32'h00000001, 16'h3F0, 32'h00000020}, // R10 other code
    '{32'h87600B0B, 32'h0B0B8604, 8'd6,  16'h3F0, 32'h00000007, 16'h3F4, 32'h00000007}, // R6 offset 0
    '{32'h8180800B, 32'h0B0B8604, 8'd3,  16'h3F4, 32'h00004000, 16'h3F0, 32'h00000006}, // R3 three deep
    '{32'hBF0B0B0B, 32'h0B0B8604, 8'd2,  16'h3F4, 32'h0000003F, 16'h3F0, 32'h00000006}, // R2 max positive
    '{32'h81810583, 32'h0B0B8604, 8'd4,  16'h3F8, 32'h00000081, 16'h3F4, 32'h00000003}  // R4 add breaks
  };

  task automatic load_prog(input logic [31:0] w0, input logic [31:0] w1);
    rst = 1'b1; clr = 1'b1; tick();
    clr = 1'b0; ld = 1'b1; ld_idx = 8'd0; ld_dat = w0; tick();
    ld_idx = 8'd1; ld_dat = w1; tick();
    ld_idx = 8'd8; ld_dat = 32'hA0040000; tick();  // trap vector 0x20: self-loop
    ld = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    // R1: reset state
    chk("R1 rd_en in reset", {31'b0, mem_rd_en}, 32'd1);
    chk("R1 wr_en in reset", {31'b0, mem_wr_en}, 32'd0);
    chk("R1 addr in reset", mem_addr, 32'd0);

    for (int v = 0; v < NV; v++) begin
      load_prog(VEC[v].w0, VEC[v].w1);
      rst = 1'b0;
      repeat (80) tick();
      chk($sformatf("R%0d vec %0d cell %h", VEC[v].req, v, VEC[v].a0),
          mem[VEC[v].a0[9:2]], VEC[v].e0);
      chk($sformatf("R%0d vec %0d cell %h", VEC[v].req, v, VEC[v].a1),
          mem[VEC[v].a1[9:2]], VEC[v].e1);
    end

    // R1: reset in the middle of an add
    load_prog(32'h830B8405, 32'h0B0B8604);
    rst = 1'b0;
    repeat (7) tick();
    rst = 1'b1; tick();
    chk("R1 mid-run reset addr", mem_addr, 32'd0);
    chk("R1 mid-run reset no write", {31'b0, mem_wr_en}, 32'd0);
    rst = 1'b0;
    chk("R1 first fetch after reset", {mem_addr[31:1], mem_rd_en}, 32'd1);
    repeat (80) tick();
    chk("R1 rerun after reset", mem[8'hFD], 32'd7);

    chk("R12 back-to-back writes", dbl_wr, 32'd0);
    chk("R12 read/write overlap", overlap, 32'd0);
    chk("R11 unaligned access", misalign, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule